// File: doc/BRIEF.md
# Eight-Bit Signed Arithmetic and Logic Unit

A purely combinational arithmetic and logic unit working on two 8-bit two's complement operands. A 4-bit operation code selects one of ten functions. These are addition, forward and reverse subtraction, three bitwise logic functions, inversion of either operand, and negation of either operand. The unit drives the 8-bit result, a signed overflow flag and a zero flag.

Independently of the selected function, three magnitude flags compare the first operand with the second under signed ordering. There is no clock, register or pipeline inside the block. Outputs follow the inputs after a short, shallow gate path.

Internally a decoder turns the operation code into a small struct of strobes. The strobes select operand inversion, operand gating, the carry-in and the result source. A datapath holds one shared adder, the logic functions and the comparator.

Top module: `alu8_twos`

## Requirements
- R1: Code 0 gives `opA + opB` modulo 256.
- R2: Code 1 gives `opA - opB` and code 2 gives `opB - opA`, both modulo 256.
- R3: Code 3 gives bitwise OR, code 4 bitwise AND, and code 5 bitwise XOR of the operands.
- R4: Code 6 gives the bitwise inverse of `opA` and code 7 the bitwise inverse of `opB`.
- R5: Code 8 gives `-opA` and code 9 gives `-opB`, each computed as inverse plus one; negating 8'h80 yields 8'h80.
- R6: Codes 10 to 15 drive a result of 8'h00 with the overflow flag low.
- R7: For codes 0, 1, 2, 8 and 9, `ovfFlag` is high exactly when the true signed result lies outside -128..127. It is low for every other code.
- R8: For every code, `aGreater`, `aLess` and `aEqual` report the signed ordering of `opA` against `opB` (8'hFF is less than 8'h01), and exactly one of them is high.
- R9: `zeroFlag` is high exactly when the 8-bit result is 8'h00.
- R10: All outputs settle to their new values after an input change, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | First signed operand |
| opB | input | 8 | Second signed operand |
| opCode | input | 4 | Operation select, 0 to 9 valid |
| result | output | 8 | Operation result |
| ovfFlag | output | 1 | Signed overflow of the arithmetic operations |
| zeroFlag | output | 1 | Result equals zero |
| aGreater | output | 1 | opA greater than opB (signed) |
| aLess | output | 1 | opA less than opB (signed) |
| aEqual | output | 1 | opA equals opB |

## Verification
The only internal state is the strobe struct between decoder and datapath. A wrong strobe, such as a missing carry-in, a wrong inversion or the wrong result source, appears at once on `result` and usually on `ovfFlag` and `zeroFlag` for that operation code. It becomes visible in the same time step as the input change, because nothing is registered. Random operand pairs across all sixteen codes, together with the 8'h80, 8'h7F, 8'h00 and 8'hFF corners, expose such faults. The same vectors expose a comparator using unsigned ordering, which shows on the magnitude flags for any pair with differing sign bits.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_ADD  = 4'd0;
  localparam logic [OP_W-1:0] OP_SUB  = 4'd1;
  localparam logic [OP_W-1:0] OP_RSUB = 4'd2;
  localparam logic [OP_W-1:0] OP_OR   = 4'd3;
  localparam logic [OP_W-1:0] OP_AND  = 4'd4;
  localparam logic [OP_W-1:0] OP_XOR  = 4'd5;
  localparam logic [OP_W-1:0] OP_NOTA = 4'd6;
  localparam logic [OP_W-1:0] OP_NOTB = 4'd7;
  localparam logic [OP_W-1:0] OP_NEGA = 4'd8;
  localparam logic [OP_W-1:0] OP_NEGB = 4'd9;
  localparam int NUM_OPS = 10;

  typedef enum logic [2:0] {
    RES_SUM, RES_OR, RES_AND, RES_XOR, RES_NOTA, RES_NOTB, RES_ZERO
  } res_e;

  typedef struct packed {
    logic passA;
    logic invA;
    logic passB;
    logic invB;
    logic carryIn;
    res_e resSel;
  } ctrl_t;
endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output ctrl_t           ctrl
);
  always_comb begin
    ctrl = '{passA: 1'b1, invA: 1'b0, passB: 1'b1, invB: 1'b0,
             carryIn: 1'b0, resSel: RES_ZERO};
    case (opCode)
      OP_ADD:  ctrl.resSel = RES_SUM;
      OP_SUB:  begin ctrl.invB = 1'b1; ctrl.carryIn = 1'b1; ctrl.resSel = RES_SUM; end
      OP_RSUB: begin ctrl.invA = 1'b1; ctrl.carryIn = 1'b1; ctrl.resSel = RES_SUM; end
      OP_OR:   ctrl.resSel = RES_OR;
      OP_AND:  ctrl.resSel = RES_AND;
      OP_XOR:  ctrl.resSel = RES_XOR;
      OP_NOTA: ctrl.resSel = RES_NOTA;
      OP_NOTB: ctrl.resSel = RES_NOTB;
      OP_NEGA: begin
        ctrl.invA = 1'b1; ctrl.passB = 1'b0; ctrl.carryIn = 1'b1; ctrl.resSel = RES_SUM;
      end
      OP_NEGB: begin
        ctrl.passA = 1'b0; ctrl.invB = 1'b1; ctrl.carryIn = 1'b1; ctrl.resSel = RES_SUM;
      end
      default: ctrl.resSel = RES_ZERO;
    endcase
  end

  always_comb begin
    // R6
    unused_code_chk: assert ((32'(opCode) < NUM_OPS) == (ctrl.resSel != RES_ZERO))
      else $error("R6: code %0d decoded to source %0d", opCode, ctrl.resSel);
  end
endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  ctrl_t            ctrl,
  output logic [WIDTH-1:0] result,
  output logic             ovfFlag,
  output logic             zeroFlag,
  output logic             aGreater,
  output logic             aLess,
  output logic             aEqual
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] addX, addY, sumVal;

  always_comb begin
    addX   = ctrl.passA ? (ctrl.invA ? ~opA : opA) : '0;
    addY   = ctrl.passB ? (ctrl.invB ? ~opB : opB) : '0;
    sumVal = addX + addY + WIDTH'(ctrl.carryIn);
    case (ctrl.resSel)
      RES_SUM:  result = sumVal;
      RES_OR:   result = opA | opB;
      RES_AND:  result = opA & opB;
      RES_XOR:  result = opA ^ opB;
      RES_NOTA: result = ~opA;
      RES_NOTB: result = ~opB;
      default:  result = '0;
    endcase
    ovfFlag  = (ctrl.resSel == RES_SUM) && (addX[MSB] == addY[MSB])
               && (sumVal[MSB] != addX[MSB]);
    zeroFlag = (result == '0);
  end

  always_comb begin
    aEqual   = (opA == opB);
    aGreater = !aEqual && ($signed(opA) > $signed(opB));
    aLess    = !aEqual && !aGreater;
  end

  always_comb begin
    // R7
    logic_ovf_chk: assert (ctrl.resSel == RES_SUM || !ovfFlag)
      else $error("R7: overflow raised for non-arithmetic source");
    // R6
    zero_source_chk: assert (ctrl.resSel != RES_ZERO || result == '0)
      else $error("R6: zero source gave %h", result);
  end

  always_comb begin
    // R8
    cmp_onehot_chk: assert ($onehot({aGreater, aLess, aEqual}))
      else $error("R8: magnitude flags not one-hot");
    // R8
    cmp_equal_chk: assert (!aEqual || (opA ^ opB) == '0)
      else $error("R8: equal flag with differing operands");
  end
endmodule

// File: rtl/alu8_twos.sv
module alu8_twos
  import alu8_pkg::*;
(
  input  logic [7:0]      opA,
  input  logic [7:0]      opB,
  input  logic [OP_W-1:0] opCode,
  output logic [7:0]      result,
  output logic            ovfFlag,
  output logic            zeroFlag,
  output logic            aGreater,
  output logic            aLess,
  output logic            aEqual
);
  ctrl_t ctrl;

  alu8_ctrl i_ctrl (.opCode(opCode), .ctrl(ctrl));

  alu8_datapath #(.WIDTH(8)) i_dp (
    .opA(opA), .opB(opB), .ctrl(ctrl), .result(result),
    .ovfFlag(ovfFlag), .zeroFlag(zeroFlag),
    .aGreater(aGreater), .aLess(aLess), .aEqual(aEqual)
  );
endmodule

// File: tb/test_alu8_twos.sv
`timescale 1ns/1ps
module test_alu8_twos;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] opA, opB, result;
  logic [3:0] opCode;
  logic ovfFlag, zeroFlag, aGreater, aLess, aEqual;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  alu8_twos i_alu8_twos (.*);

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1, 4'd2: return "R2";
      4'd3, 4'd4, 4'd5: return "R3";
      4'd6, 4'd7: return "R4";
      4'd8, 4'd9: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic int trueVal(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    int sa = $signed(a);
    int sb = $signed(b);
    case (op)
      4'd0: return sa + sb;
      4'd1: return sa - sb;
      4'd2: return sb - sa;
      4'd3: return int'(a | b);
      4'd4: return int'(a & b);
      4'd5: return int'(a ^ b);
      4'd6: return int'(~a);
      4'd7: return int'(~b);
      4'd8: return -sa;
      4'd9: return -sb;
      default: return 0;
    endcase
  endfunction

  function automatic logic expOvf(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    int t = trueVal(op, a, b);
    if (op <= 4'd2 || op == 4'd8 || op == 4'd9) return (t > 127) || (t < -128);
    return 1'b0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (op=%0d a=%h b=%h)", tag, act, exp, opCode, opA, opB);
    end
  endtask

  task automatic checkAll();
    logic [7:0] er = 8'(trueVal(opCode, opA, opB));
    int sa = $signed(opA);
    int sb = $signed(opB);
    check(tagOf(opCode), int'(result), int'(er));
    check("R7", int'(ovfFlag), int'(expOvf(opCode, opA, opB)));
    check("R9", int'(zeroFlag), int'(er == 8'h00));
    check("R8", int'({aGreater, aLess, aEqual}), int'({sa > sb, sa < sb, sa == sb}));
  endtask

  task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    opCode = op; opA = a; opB = b;
    #1 checkAll();
  endtask

  initial begin
    opCode = 4'd0; opA = 8'h00; opB = 8'h00;
    #1;
    // initial state with all-zero inputs
    check("R9", int'(zeroFlag), 1);
    check("R8", int'({aGreater, aLess, aEqual}), 3'b001);
    check("R1", int'(result), 0);

    // directed corners
    apply(4'd8, 8'h80, 8'h00);
    check("R5", int'(result), 8'h80);
    check("R7", int'(ovfFlag), 1);
    apply(4'd9, 8'h00, 8'h00);
    check("R5", int'(ovfFlag), 0);
    apply(4'd0, 8'h7F, 8'h01);
    check("R7", int'(ovfFlag), 1);
    apply(4'd1, 8'h00, 8'h80);
    check("R2", int'(result), 8'h80);
    apply(4'd2, 8'h80, 8'h00);
    apply(4'd0, 8'hFF, 8'h01);
    check("R8", int'(aLess), 1);
    for (int op = 0; op < 16; op++) begin
      apply(4'(op), 8'h80, 8'h7F);
      apply(4'(op), 8'h7F, 8'h80);
      apply(4'(op), 8'hFF, 8'hFF);
    end
    for (int op = 10; op < 16; op++) apply(4'(op), 8'h5A, 8'hC3);

    // R10: inputs change twice within one clock period, outputs follow each time
    @(posedge clk);
    #0.5 opCode = 4'd3; opA = 8'h0F; opB = 8'hF0;
    #0.5 check("R10", int'(result), 8'hFF);
    #0.5 opB = 8'h0F;
    #0.5 check("R10", int'(result), 8'h0F);
    check("R10", int'(aEqual), 1);

    // constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 20000; i++) begin
      logic [7:0] a, b;
      logic [3:0] op;
      a = 8'($urandom);
      b = 8'($urandom);
      op = 4'($urandom_range(0, 15));
      if ((i % 8) == 0) a = (i % 16 == 0) ? 8'h80 : 8'h7F;
      if ((i % 7) == 0) b = a;
      apply(op, a, b);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule